// File: doc/BRIEF.md
# Four-by-Four Box Averager

This block smooths a raster stream of unsigned derivative-product samples (such as squared gradients or gradient cross products) over a four-row by four-column window, ahead of a corner-response stage. Each sample that arrives while the frame is active is written into one of four single-line memories. The memories form a ring, so the line being written always replaces the oldest stored line. A frame holds up to `LINE` samples per line (638 by default, because a 640-pixel line loses its first and last gradient column).

After three full lines are stored, every incoming sample completes one column of four vertically aligned values. The three older values come from the ring memories, which are read in the same cycle as the write, and the fourth is the incoming sample itself. The column is put into top-to-bottom order and shifted into a four-by-four window of registers. Once the window holds four columns of the current line, the block adds all sixteen values and drops four bits. The result is the box average, and it is presented with a one-cycle valid strobe. Three instances serve the three product streams of a corner detector.

Top module: `box_avg4x4`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is low until a full box has been collected.
- R2: No average is produced for any sample in the first three lines of a frame.
- R3: For the sample at line r and column c, with r and c both at least 3 and counted from 0 in the frame, `out_avg` equals floor(S/16). S is the sum of the 16 samples at lines r-3..r and columns c-3..c.
- R4: Within a line, the first three columns produce no average, so no box straddles two lines. A frame of N lines (N >= 4) yields exactly (N-3)*(LINE-3) averages.
- R5: Only cycles with both `in_valid` and `frame_valid` high advance the block. Idle gaps between samples do not change any result, and each average appears on the second rising edge after the sample that completes its box.
- R6: Dropping `frame_valid` resets the line and column position, even mid-line. The next frame again suppresses output for its first three lines, and its boxes use only its own samples.
- R7: Samples presented while `frame_valid` is low are discarded, produce no output and do not disturb the next frame.
- R8: Sixteen samples at full scale (all ones) yield an average of all ones, with no overflow.
- R9: Lines beyond the fourth reuse the ring memories in rotation, and the averages stay correct from the fifth line on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid | input | 1 | High while a frame is in progress; low resets position |
| in_valid | input | 1 | Sample strobe |
| in_data | input | DW | Unsigned sample value |
| out_valid | output | 1 | One-cycle strobe marking a new average |
| out_avg | output | DW | Box average, sum of 16 samples divided by 16 |

## Verification
The assertions take for granted that a frame is a plain raster: samples arrive line by line, each line is exactly `LINE` accepted samples long, and a frame that ends early is closed by lowering `frame_valid`. On those assumptions they check the timing of output against accepted input and that the held average changes only with a strobe. The stimulus keeps to these assumptions. It raises `frame_valid` before the first sample and counts out whole lines, with random idle gaps between samples. The only partial line it sends is the one cut short by an early `frame_valid` drop, which is the case under test. Samples offered while `frame_valid` is low lie outside any frame, so the design must discard them.

// File: rtl/box_avg4x4.sv
module box_avg4x4 #(
  parameter int DW   = 18,
  parameter int LINE = 638
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_valid,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_avg
);
  localparam int CW = $clog2(LINE);
  localparam int AW = DW + 4;
  localparam logic [CW-1:0] LAST = CW'(LINE - 1);

  logic          take, rows_ready, line_end, stage_v;
  logic [CW-1:0] col;
  logic [1:0]    wr_row, rows_done;
  logic [2:0]    fill;
  logic [DW-1:0] rd   [4];
  logic [DW-1:0] colv [4];
  logic [DW-1:0] win  [4][4];
  logic [AW-1:0] sum;

  assign take       = frame_valid & in_valid;
  assign rows_ready = (rows_done == 2'd3);
  assign line_end   = (col == LAST);

  for (genvar g = 0; g < 4; g++) begin : g_row
    logic [DW-1:0] ram [LINE];
    always_ff @(posedge clk)
      if (take && wr_row == 2'(g)) ram[col] <= in_data;
    assign rd[g] = ram[col];
  end

  for (genvar k = 0; k < 3; k++) begin : g_order
    assign colv[k] = rd[2'(wr_row + 2'(k + 1))];
  end
  assign colv[3] = in_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      col <= '0; wr_row <= '0; rows_done <= '0;
    end else if (!frame_valid) begin
      col <= '0; wr_row <= '0; rows_done <= '0;
    end else if (take) begin
      if (line_end) begin
        col       <= '0;
        wr_row    <= wr_row + 2'd1;
        rows_done <= rows_ready ? rows_done : rows_done + 2'd1;
      end else begin
        col <= col + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fill <= '0; stage_v <= 1'b0;
    end else begin
      stage_v <= 1'b0;
      if (!frame_valid) fill <= '0;
      else if (take && rows_ready) begin
        if (col == '0) fill <= 3'd1;
        else           fill <= (fill == 3'd4) ? fill : fill + 3'd1;
        stage_v <= (col != '0) && (fill >= 3'd3);
      end
    end

  always_ff @(posedge clk)
    if (take && rows_ready)
      for (int k = 0; k < 4; k++) begin
        win[k][0] <= colv[k];
        for (int j = 1; j < 4; j++) win[k][j] <= win[k][j-1];
      end

  always_comb begin
    sum = '0;
    for (int k = 0; k < 4; k++)
      for (int j = 0; j < 4; j++) sum = sum + AW'(win[k][j]);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0; out_avg <= '0;
    end else begin
      out_valid <= stage_v;
      if (stage_v) out_avg <= sum[AW-1:4];
    end
endmodule

// File: rtl/box_avg4x4_chk.sv
module box_avg4x4_chk #(
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_valid,
  input logic          in_valid,
  input logic          out_valid,
  input logic [DW-1:0] out_avg
);
  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

  p_out_after_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && frame_valid, 2));

  p_no_out_outside_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |=> ##1 !out_valid);

  p_hold_avg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_avg));
endmodule

bind box_avg4x4 box_avg4x4_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid),
  .in_valid(in_valid), .out_valid(out_valid), .out_avg(out_avg)
);

// File: tb/tb_box_avg4x4.sv
module tb_box_avg4x4;
  localparam int DW   = 18;
  localparam int LINE = 638;

  logic clk = 1'b0, rst_n = 1'b0, frame_valid = 1'b0, in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic out_valid;
  logic [DW-1:0] out_avg;

  box_avg4x4 #(.DW(DW), .LINE(LINE)) dut (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .in_valid(in_valid),
    .in_data(in_data), .out_valid(out_valid), .out_avg(out_avg));

  always #5 clk = ~clk;

  int checks = 0, failures = 0, got = 0;
  string phase = "R2";
  logic [DW-1:0] exp_q [$];
  string         tag_q [$];
  logic [DW-1:0] img [4][LINE];
  bit done = 0;

  always @(negedge clk) if (out_valid) begin
    got++;
    checks++;
    if (exp_q.size() == 0) begin
      failures++;
      $display("FAIL %s unexpected output actual=%0h expected=none", phase, out_avg);
    end else begin
      logic [DW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (out_avg !== e) begin
        failures++;
        $display("FAIL %s average actual=%0h expected=%0h", t, out_avg, e);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input int r, input int c, input logic [DW-1:0] v,
                      input int gap, input string tag);
    repeat (gap) begin @(negedge clk); in_valid = 1'b0; end
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = v;
    img[r % 4][c] = v;
    if (r >= 3 && c >= 3) begin
      logic [DW+3:0] s;
      s = '0;
      for (int rr = r - 3; rr <= r; rr++)
        for (int cc = c - 3; cc <= c; cc++) s += (DW+4)'(img[rr % 4][cc]);
      exp_q.push_back(s[DW+3:4]);
      tag_q.push_back(r >= 4 ? "R9" : tag);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk); in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // mode 0: random data, 1: random with gaps, 2: full scale
  task automatic frame(input int rows, input int cols_last, input int mode, input string tag);
    @(negedge clk); frame_valid = 1'b1;
    for (int r = 0; r < rows; r++) begin
      phase = (r < 3) ? "R2" : tag;
      for (int c = 0; c < ((r == rows - 1) ? cols_last : LINE); c++) begin
        logic [DW-1:0] v;
        v = (mode == 2) ? {DW{1'b1}} : DW'($urandom_range(0, (1 << DW) - 1));
        send(r, c, v, (mode == 1) ? $urandom_range(0, 2) : 0, tag);
      end
    end
    idle(4);
    frame_valid = 1'b0;
    idle(3);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1", out_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(out_valid === 1'b0, "R1", out_valid, 0);

    // six lines with random gaps
    got = 0;
    frame(6, LINE, 1, "R5");
    check(got == 3 * (LINE - 3), "R5", got, 3 * (LINE - 3));
    check(exp_q.size() == 0, "R5", exp_q.size(), 0);

    // back-to-back, four lines
    got = 0;
    frame(4, LINE, 0, "R4");
    check(got == LINE - 3, "R4", got, LINE - 3);

    // abort mid-line of line five
    got = 0;
    frame(5, 200, 0, "R3");
    check(got == (LINE - 3) + 197, "R6", got, (LINE - 3) + 197);
    exp_q.delete(); tag_q.delete();

    // samples outside a frame must be ignored
    got = 0;
    phase = "R7";
    for (int i = 0; i < 50; i++) begin
      @(negedge clk); in_valid = 1'b1; in_data = DW'(i * 977);
    end
    idle(4);
    check(got == 0, "R7", got, 0);

    // new frame after abort
    got = 0;
    frame(4, LINE, 0, "R6");
    check(got == LINE - 3, "R6", got, LINE - 3);

    // full scale
    got = 0;
    frame(4, 10, 2, "R8");
    check(got == 7, "R8", got, 7);
    check(exp_q.size() == 0, "R8", exp_q.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule